// File: doc/BRIEF.md
# Storage Host Controller Register and Interrupt Unit

This block is the register file of a multi-port serial storage host controller. It holds a small global host region and one register window for each port. It merges the interrupt sources of all ports into a single interrupt line. Software reaches it through a plain 32-bit bus with an address, a write strobe, write data and combinational read data.

The per-port event logic outside this block drives one-cycle bit pulses into each port's interrupt status and link error registers. The block drives the interrupt line, a one-cycle port reset request and the per-port start and frame-receive enables. Command execution, memory traffic for frames and the physical link all live outside it.

The global host region spans addresses 0x000 to 0x0FF. Port p's window starts at 0x100 + p*128. Inside a window, the port's status register is at +0x10, its enable at +0x14, its command register at +0x18, link status at +0x28, link control at +0x2C, link error at +0x30, active tags at +0x34 and command issue at +0x38. The global registers are: capability at 0x00, control at 0x04, interrupt summary at 0x08 and implemented-ports at 0x0C.

Top module: `hba_regs_top`

## Requirements
- R1: The port index is (address - 0x100) >> 7. A read of an offset that is not listed, or of a window past the last port, returns 0.
- R2: Each bit set in a port's event input sets the same bit of that port's interrupt status. A write to the status clears the bits that are 1 in the data. When a bit is set and cleared in the same cycle, the set wins.
- R3: A write to a port's interrupt enable stores the data ANDed with 0xFDC000FF.
- R4: Bit i of the global interrupt summary is 1 exactly when port i has (status AND enable) nonzero. A write to the summary leaves its value unchanged.
- R5: The interrupt output is 1 exactly when the summary is nonzero and control bit 1 (interrupt enable) is 1.
- R6: A control write with bit 0 set returns every register to its reset value at that edge. Any other control write stores data bits 1:0 and reads back with bit 31 forced to 1.
- R7: In the command register, writes to bits 15 and 14 are dropped. Bit 15 reads as bit 0 (start) and bit 14 reads as bit 4 (frame receive). The outputs cmd_start and fis_rx_en carry bits 0 and 4.
- R8: A link control write that changes bits 3:0 from 1 to 0 raises port_rst_req for exactly one cycle after the write edge. The same write clears that port's link error and active-tag registers. The command-issue register is not affected.
- R9: A write to link error clears the written bits, and the error event input sets bits. Writes to active tags and to command issue OR the data into the register.
- R10: Link status reads 0x113 when the port's device-present input is 1 and 0 when it is 0.
- R11: A write whose address bits 1:0 are not 00 changes no register.
- R12: After reset, each command register reads 0x6, status and enable registers read 0, and control reads 0x80000000. Capability reads (ports-1) in bits 4:0, (slots-1) in bits 12:8, 1 in bits 23:20, and bits 18 and 30 set (0x40141F03 for 4 ports and 32 slots). Implemented-ports reads (1<<ports)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| port_irq_set | input | NUM_PORTS*32 | Interrupt event pulses, 32 bits per port |
| port_err_set | input | NUM_PORTS*32 | Link error event pulses, 32 bits per port |
| dev_present | input | NUM_PORTS | Device attached, one bit per port |
| irq | output | 1 | Combined interrupt line |
| port_rst_req | output | NUM_PORTS | One-cycle port reset request |
| cmd_start | output | NUM_PORTS | Start bit of each port's command register |
| fis_rx_en | output | NUM_PORTS | Frame-receive enable bit of each port |

## Verification
A behavioural model compares read data, the interrupt line and every per-port output on every cycle. The sequence includes a status write that lands in the same cycle as an event pulse on the same bit, which shows whether set or clear wins. Link control goes 1 then 0, and also 2 then 0, so a correct edge detector can be told apart from a plain zero detector. All-ones writes to the enable and command registers expose masking errors. Misaligned, out-of-range and unlisted addresses show whether the decode ignores them. A soft reset written in the middle of activity shows whether every register returns to its reset value at once.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;

    localparam logic [7:0] H_CAP  = 8'h00;
    localparam logic [7:0] H_CTL  = 8'h04;
    localparam logic [7:0] H_SUM  = 8'h08;
    localparam logic [7:0] H_IMPL = 8'h0C;

    localparam logic [7:0] P_STAT = 8'h10;
    localparam logic [7:0] P_ENAB = 8'h14;
    localparam logic [7:0] P_CMD  = 8'h18;
    localparam logic [7:0] P_LSTS = 8'h28;
    localparam logic [7:0] P_LCTL = 8'h2C;
    localparam logic [7:0] P_LERR = 8'h30;
    localparam logic [7:0] P_ACT  = 8'h34;
    localparam logic [7:0] P_ISSU = 8'h38;

    localparam logic [31:0] ENAB_MASK = 32'hFDC0_00FF;
    localparam logic [31:0] LINK_UP   = 32'h0000_0113;
    localparam logic [31:0] CMD_INIT  = 32'h0000_0006;
    localparam logic [31:0] CTL_INIT  = 32'h8000_0000;

    localparam int CMD_ST  = 0;
    localparam int CMD_FRE = 4;
    localparam int CMD_FR  = 14;
    localparam int CMD_CR  = 15;
    localparam int CTL_HR  = 0;
    localparam int CTL_IE  = 1;

    typedef struct packed {
        logic        en;
        logic [7:0]  off;
        logic [31:0] data;
    } reg_wr_t;

    function automatic logic [31:0] cap_word(int unsigned nports, int unsigned nslots);
        logic [31:0] c;
        c        = '0;
        c[4:0]   = 5'(nports - 1);
        c[12:8]  = 5'(nslots - 1);
        c[23:20] = 4'd1;
        c[18]    = 1'b1;
        c[30]    = 1'b1;
        return c;
    endfunction

    function automatic logic [31:0] impl_mask(int unsigned nports);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < int'(nports)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] cmd_view(logic [31:0] stored);
        logic [31:0] v;
        v         = stored;
        v[CMD_CR] = stored[CMD_ST];
        v[CMD_FR] = stored[CMD_FRE];
        return v;
    endfunction

endpackage

// File: rtl/hba_port_regs.sv
module hba_port_regs
    import hba_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reg_wr_t     wr,
    input  logic [7:0]  rd_off,
    output logic [31:0] rd_data,
    input  logic [31:0] irq_set,
    input  logic [31:0] err_set,
    input  logic        dev_present,
    output logic        pending,
    output logic        start,
    output logic        fis_rx,
    output logic        rst_req
);

    logic [31:0] stat_q, enab_q, cmd_q, lctl_q, lerr_q, act_q, issu_q;
    logic        rst_req_q;

    logic w_stat, w_enab, w_cmd, w_lctl, w_lerr, w_act, w_issu;
    logic det_fall;

    assign w_stat = wr.en && (wr.off == P_STAT);
    assign w_enab = wr.en && (wr.off == P_ENAB);
    assign w_cmd  = wr.en && (wr.off == P_CMD);
    assign w_lctl = wr.en && (wr.off == P_LCTL);
    assign w_lerr = wr.en && (wr.off == P_LERR);
    assign w_act  = wr.en && (wr.off == P_ACT);
    assign w_issu = wr.en && (wr.off == P_ISSU);

    assign det_fall = w_lctl && (lctl_q[3:0] == 4'd1) && (wr.data[3:0] == 4'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            enab_q    <= '0;
            cmd_q     <= CMD_INIT;
            lctl_q    <= '0;
            lerr_q    <= '0;
            act_q     <= '0;
            issu_q    <= '0;
            rst_req_q <= 1'b0;
        end else begin
            stat_q <= (w_stat ? (stat_q & ~wr.data) : stat_q) | irq_set;
            if (w_enab) enab_q <= wr.data & ENAB_MASK;
            if (w_cmd) begin
                cmd_q         <= wr.data;
                cmd_q[CMD_CR] <= 1'b0;
                cmd_q[CMD_FR] <= 1'b0;
            end
            if (w_lctl) lctl_q <= wr.data;
            if (det_fall)    lerr_q <= '0;
            else             lerr_q <= (w_lerr ? (lerr_q & ~wr.data) : lerr_q) | err_set;
            if (det_fall)    act_q <= '0;
            else if (w_act)  act_q <= act_q | wr.data;
            if (w_issu) issu_q <= issu_q | wr.data;
            rst_req_q <= det_fall;
        end
    end

    always_comb begin
        case (rd_off)
            P_STAT:  rd_data = stat_q;
            P_ENAB:  rd_data = enab_q;
            P_CMD:   rd_data = cmd_view(cmd_q);
            P_LSTS:  rd_data = dev_present ? LINK_UP : 32'h0;
            P_LCTL:  rd_data = lctl_q;
            P_LERR:  rd_data = lerr_q;
            P_ACT:   rd_data = act_q;
            P_ISSU:  rd_data = issu_q;
            default: rd_data = 32'h0;
        endcase
    end

    assign pending = |(stat_q & enab_q);
    assign start   = cmd_q[CMD_ST];
    assign fis_rx  = cmd_q[CMD_FRE];
    assign rst_req = rst_req_q;

    AST_ENAB_MASKED: assert property (@(posedge clk) disable iff (rst)
        w_enab |=> (enab_q == ($past(wr.data) & ENAB_MASK))); // R3

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
        (w_stat && (irq_set == 32'h0)) |=> ((stat_q & $past(wr.data)) == 32'h0)); // R2

    AST_RST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R8

    AST_ACT_ONLY_GROWS: assert property (@(posedge clk) disable iff (rst)
        !det_fall |=> ((act_q & $past(act_q)) == $past(act_q))); // R9

endmodule

// File: rtl/hba_host_regs.sv
module hba_host_regs
    import hba_regs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    input  logic [7:0]           rd_off,
    input  logic [NUM_PORTS-1:0] pend_vec,
    output logic [31:0]          rd_data,
    output logic                 soft_rst,
    output logic                 irq
);

    localparam logic [31:0] CAP_VAL  = cap_word(NUM_PORTS, NUM_SLOTS);
    localparam logic [31:0] IMPL_VAL = impl_mask(NUM_PORTS);

    logic [31:0] ctl_q;
    logic        w_ctl;
    logic        unused_ctl_bits;

    assign w_ctl           = wr.en && (wr.off == H_CTL);
    assign soft_rst        = w_ctl && wr.data[CTL_HR];
    assign unused_ctl_bits = ^wr.data[31:2];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctl_q <= CTL_INIT;
        end else if (w_ctl) begin
            ctl_q <= CTL_INIT | {30'h0, wr.data[1:0]};
        end
    end

    always_comb begin
        case (rd_off)
            H_CAP:   rd_data = CAP_VAL;
            H_CTL:   rd_data = ctl_q;
            H_SUM:   rd_data = 32'(pend_vec);
            H_IMPL:  rd_data = IMPL_VAL;
            default: rd_data = 32'h0;
        endcase
    end

    assign irq = (|pend_vec) && ctl_q[CTL_IE];

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (w_ctl && !wr.data[CTL_HR]) |=> (ctl_q == (CTL_INIT | {30'h0, $past(wr.data[1:0])}))); // R6

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (ctl_q == CTL_INIT)); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctl_q[CTL_IE] && (pend_vec != '0))); // R5

endmodule

// File: rtl/hba_regs_top.sv
module hba_regs_top
    import hba_regs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_PORTS*32-1:0] port_irq_set,
    input  logic [NUM_PORTS*32-1:0] port_err_set,
    input  logic [NUM_PORTS-1:0]    dev_present,
    output logic                    irq,
    output logic [NUM_PORTS-1:0]    port_rst_req,
    output logic [NUM_PORTS-1:0]    cmd_start,
    output logic [NUM_PORTS-1:0]    fis_rx_en
);

    localparam int                STRIDE_SH = 7;
    localparam int                IDX_W     = ADDR_W - STRIDE_SH;
    localparam logic [ADDR_W-1:0] PORT_BASE = ADDR_W'(256);

    logic              aligned, host_hit, port_hit, soft_rst, any_rst;
    logic [ADDR_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic [31:0]       host_rd;
    logic [31:0]       port_rd [NUM_PORTS];
    logic [NUM_PORTS-1:0] pend_vec;
    reg_wr_t           host_wr;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign host_hit = (bus_addr < PORT_BASE);
    assign rel      = bus_addr - PORT_BASE;
    assign idx      = rel[ADDR_W-1:STRIDE_SH];
    assign port_hit = !host_hit && (idx < IDX_W'(NUM_PORTS));
    assign any_rst  = rst || soft_rst;

    assign host_wr = '{en: bus_we && aligned && host_hit, off: bus_addr[7:0], data: bus_wdata};

    hba_host_regs #(
        .NUM_PORTS(NUM_PORTS),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_host (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_wr),
        .rd_off   (bus_addr[7:0]),
        .pend_vec (pend_vec),
        .rd_data  (host_rd),
        .soft_rst (soft_rst),
        .irq      (irq)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        reg_wr_t pw;
        assign pw = '{en:   bus_we && aligned && port_hit && (idx == IDX_W'(p)),
                      off:  {1'b0, rel[STRIDE_SH-1:0]},
                      data: bus_wdata};

        hba_port_regs u_port (
            .clk         (clk),
            .rst         (any_rst),
            .wr          (pw),
            .rd_off      ({1'b0, rel[STRIDE_SH-1:0]}),
            .rd_data     (port_rd[p]),
            .irq_set     (port_irq_set[p*32 +: 32]),
            .err_set     (port_err_set[p*32 +: 32]),
            .dev_present (dev_present[p]),
            .pending     (pend_vec[p]),
            .start       (cmd_start[p]),
            .fis_rx      (fis_rx_en[p]),
            .rst_req     (port_rst_req[p])
        );
    end

    always_comb begin
        bus_rdata = 32'h0;
        if (host_hit) bus_rdata = host_rd;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_hit && (idx == IDX_W'(p))) bus_rdata = port_rd[p];
        end
    end

    AST_MISALIGNED_NO_RESET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !aligned) |=> (port_rst_req == '0)); // R11

endmodule

// File: tb/hba_regs_top_test.sv
module hba_regs_top_test;

    localparam int N  = 4;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N*32-1:0] port_irq_set = '0;
    logic [N*32-1:0] port_err_set = '0;
    logic [N-1:0]    dev_present = '0;
    logic            irq;
    logic [N-1:0]    port_rst_req, cmd_start, fis_rx_en;

    hba_regs_top #(.NUM_PORTS(N), .NUM_SLOTS(32), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_irq_set(port_irq_set), .port_err_set(port_err_set),
        .dev_present(dev_present), .irq(irq), .port_rst_req(port_rst_req),
        .cmd_start(cmd_start), .fis_rx_en(fis_rx_en)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    logic [31:0] m_is [N], m_ie [N], m_cmd [N], m_sctl [N], m_serr [N], m_sact [N], m_ci [N];
    logic [N-1:0] m_rq;
    logic [31:0] m_ctl;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int a, base, off;
        bit hard, hit, fall;
        a = int'(bus_addr);
        hard = rst || (bus_we && a == 4 && bus_wdata[0]);
        if (hard) begin
            for (int p = 0; p < N; p++) begin
                m_is[p] = 0; m_ie[p] = 0; m_cmd[p] = 6; m_sctl[p] = 0;
                m_serr[p] = 0; m_sact[p] = 0; m_ci[p] = 0;
            end
            m_rq  = '0;
            m_ctl = 32'h8000_0000;
        end else begin
            if (bus_we && a == 4) m_ctl = 32'h8000_0000 + (bus_wdata & 32'h3);
            for (int p = 0; p < N; p++) begin
                base = 256 + p * 128;
                hit  = bus_we && (a % 4 == 0) && a >= base && a < base + 128;
                off  = a - base;
                if (hit && off == 16) m_is[p] = m_is[p] & ~bus_wdata;
                m_is[p] = m_is[p] | port_irq_set[p*32 +: 32];
                if (hit && off == 20) m_ie[p] = bus_wdata & 32'hFDC0_00FF;
                if (hit && off == 24) m_cmd[p] = bus_wdata & 32'hFFFF_3FFF;
                fall = hit && off == 44 && m_sctl[p][3:0] == 1 && bus_wdata[3:0] == 0;
                if (hit && off == 44) m_sctl[p] = bus_wdata;
                if (hit && off == 48) m_serr[p] = m_serr[p] & ~bus_wdata;
                m_serr[p] = m_serr[p] | port_err_set[p*32 +: 32];
                if (hit && off == 52) m_sact[p] = m_sact[p] | bus_wdata;
                if (hit && off == 56) m_ci[p] = m_ci[p] | bus_wdata;
                if (fall) begin
                    m_serr[p] = 0;
                    m_sact[p] = 0;
                end
                m_rq[p] = fall;
            end
        end
    end

    function automatic logic [31:0] m_sum();
        logic [31:0] s = 0;
        for (int p = 0; p < N; p++) if ((m_is[p] & m_ie[p]) != 0) s[p] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        int p, off;
        if (a < 256) begin
            case (a)
                0:  return 32'h4014_1F03;
                4:  return m_ctl;
                8:  return m_sum();
                12: return 32'hF;
                default: return 0;
            endcase
        end
        p = (a - 256) / 128;
        off = (a - 256) % 128;
        if (p >= N) return 0;
        case (off)
            16: return m_is[p];
            20: return m_ie[p];
            24: return m_cmd[p] | (32'(m_cmd[p][0]) << 15) | (32'(m_cmd[p][4]) << 14);
            40: return dev_present[p] ? 32'h113 : 32'h0;
            44: return m_sctl[p];
            48: return m_serr[p];
            52: return m_sact[p];
            56: return m_ci[p];
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        int off;
        if (a < 256) begin
            case (a)
                0, 12: return "R12";
                4:  return "R6";
                8:  return "R4";
                default: return "R1";
            endcase
        end
        if (a >= 256 + N * 128) return "R1";
        off = (a - 256) % 128;
        case (off)
            16: return "R2";
            20: return "R3";
            24: return "R7";
            40: return "R10";
            44: return "R8";
            48, 52, 56: return "R9";
            default: return "R1";
        endcase
    endfunction

    always @(negedge clk) begin
        #2;
        if (cmp_on && !done) begin
            logic [N-1:0] st, fr;
            for (int p = 0; p < N; p++) begin
                st[p] = m_cmd[p][0];
                fr[p] = m_cmd[p][4];
            end
            check(tag_of(int'(bus_addr)), bus_rdata, exp_rd(int'(bus_addr)));
            check("R5", 32'(irq), 32'((m_sum() != 0) && m_ctl[1]));
            check("R8", 32'(port_rst_req), 32'(m_rq));
            check("R7", 32'({cmd_start, fis_rx_en}), 32'({st, fr}));
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = AW'(a);
        #2;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(int p, logic [31:0] ib, logic [31:0] eb);
        @(negedge clk);
        port_irq_set[p*32 +: 32] = ib;
        port_err_set[p*32 +: 32] = eb;
        @(negedge clk);
        port_irq_set = '0;
        port_err_set = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R12 reset values
        rd_chk(12'h118, 32'h6, "R12");
        rd_chk(12'h190, 32'h0, "R12");
        rd_chk(12'h000, 32'h4014_1F03, "R12");
        rd_chk(12'h00C, 32'hF, "R12");
        rd_chk(12'h004, 32'h8000_0000, "R12");
        // R3 enable mask
        wr(12'h194, 32'hFFFF_FFFF);
        rd_chk(12'h194, 32'hFDC0_00FF, "R3");
        // R2 set, clear, set-wins
        pulse(1, 32'h21, 32'h0);
        rd_chk(12'h190, 32'h21, "R2");
        wr(12'h190, 32'h1);
        rd_chk(12'h190, 32'h20, "R2");
        @(negedge clk);
        bus_addr = 12'h190; bus_wdata = 32'h1; bus_we = 1'b1;
        port_irq_set[63:32] = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; port_irq_set = '0;
        rd_chk(12'h190, 32'h21, "R2");
        // R4 summary, write has no effect
        rd_chk(12'h008, 32'h2, "R4");
        wr(12'h008, 32'hF);
        rd_chk(12'h008, 32'h2, "R4");
        // R5 interrupt gate
        check("R5", 32'(irq), 32'h0);
        wr(12'h004, 32'h2);
        #2 check("R5", 32'(irq), 32'h1);
        rd_chk(12'h004, 32'h8000_0002, "R6");
        wr(12'h194, 32'h0);
        #2 check("R5", 32'(irq), 32'h0);
        // R7 command register
        wr(12'h218, 32'hFFFF_FFFF);
        rd_chk(12'h218, 32'hFFFF_FFFF, "R7");
        wr(12'h218, 32'h0000_C000);
        rd_chk(12'h218, 32'h0, "R7");
        wr(12'h218, 32'h1);
        rd_chk(12'h218, 32'h8001, "R7");
        check("R7", 32'({cmd_start[2], fis_rx_en[2]}), 32'h2);
        wr(12'h218, 32'h10);
        rd_chk(12'h218, 32'h4010, "R7");
        // R9 link error, active, issue
        pulse(3, 32'h0, 32'h3);
        wr(12'h2B0, 32'h1);
        rd_chk(12'h2B0, 32'h2, "R9");
        wr(12'h2B4, 32'h1);
        wr(12'h2B4, 32'h4);
        rd_chk(12'h2B4, 32'h5, "R9");
        wr(12'h2B8, 32'h8);
        wr(12'h2B8, 32'h2);
        rd_chk(12'h2B8, 32'hA, "R9");
        // R8 detect falling edge
        wr(12'h2AC, 32'h2);
        wr(12'h2AC, 32'h0);
        #2 check("R8", 32'(port_rst_req), 32'h0);
        wr(12'h2AC, 32'h1);
        wr(12'h2AC, 32'h0);
        #2 check("R8", 32'(port_rst_req), 32'h8);
        @(negedge clk);
        #2 check("R8", 32'(port_rst_req), 32'h0);
        rd_chk(12'h2B0, 32'h0, "R8");
        rd_chk(12'h2B4, 32'h0, "R8");
        rd_chk(12'h2B8, 32'hA, "R8");
        // R10 link status
        dev_present = 4'b0001;
        rd_chk(12'h128, 32'h113, "R10");
        rd_chk(12'h1A8, 32'h0, "R10");
        // R11 misaligned write
        wr(12'h195, 32'h0);
        wr(12'h196, 32'h0);
        wr(12'h194, 32'h3);
        wr(12'h197, 32'h0);
        rd_chk(12'h194, 32'h3, "R11");
        // R1 decode
        rd_chk(12'h300, 32'h0, "R1");
        rd_chk(12'h11C, 32'h0, "R1");
        rd_chk(12'h010, 32'h0, "R1");
        wr(12'h394, 32'hFF);
        rd_chk(12'h194, 32'h3, "R1");
        // R6 soft reset mid-activity
        wr(12'h004, 32'h3);
        rd_chk(12'h004, 32'h8000_0000, "R6");
        rd_chk(12'h194, 32'h0, "R6");
        rd_chk(12'h218, 32'h6, "R6");
        rd_chk(12'h190, 32'h0, "R6");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule